// File: doc/BRIEF.md
# Transition Fault Injection Cell

This cell sits on a single net inside an at-speed fault-grading or emulation harness. It models a delay defect whose size is a whole number of clock cycles. A slow-to-rise defect holds a rising edge back. A slow-to-fall defect holds a falling edge back. The net's fault-free value arrives in three-valued form (0, 1, unknown). The cell returns the value the defective net would carry in the current vector frame.

The cell keeps a shift register of the net's fault-free values, one entry per applied vector, up to a depth fixed at compile time. The harness pulses a strobe at the end of each vector's evaluation. The runtime size input picks how many of the newest entries take part. Slow-to-rise combines those entries with the current value through a three-valued AND. Slow-to-fall combines them through a three-valued OR. A transition therefore stays suppressed until the net has held its new value for the whole fault size. After reset, every stored frame is unknown, so a rising value under a slow-to-rise defect comes out unknown rather than 1.

Top module: `tfi_cell`

## Requirements
- R1: Values use a 2-bit code: 2'b00 is 0, 2'b01 is 1, and 2'b10 or 2'b11 is unknown. Whenever the cell is injecting, an unknown result is driven as 2'b10 and never as 2'b11.
- R2: With rise_mode=1, en=1 and 1 <= size <= KMAX, fault_out is the three-valued AND of good_in and the newest `size` stored frames. Any 0 gives 0. All 1 gives 1. Anything else gives unknown. The result follows good_in in the same cycle, with no register.
- R3: With rise_mode=0, en=1 and 1 <= size <= KMAX, fault_out is the three-valued OR of good_in and the newest `size` stored frames. Any 1 gives 1. All 0 gives 0. Anything else gives unknown.
- R4: The history takes in good_in (the fault-free value, before injection) only on a rising clock edge where strobe=1. On every other edge the stored frames stay unchanged.
- R5: A synchronous reset (rst=1 at a clock edge) fills every stored frame with unknown. Right after reset, a slow-to-rise cell of size 1 with good_in=1 outputs unknown, and with good_in=0 it outputs 0.
- R6: With en=0, fault_out equals good_in, and the history keeps shifting on strobe.
- R7: A size of 0, or any size above KMAX, turns injection off, and fault_out equals good_in.
- R8: Frames older than the newest `size` frames have no effect on fault_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; sets the history to unknown |
| en | input | 1 | Injection enable |
| rise_mode | input | 1 | 1 = slow-to-rise defect, 0 = slow-to-fall defect |
| size | input | $clog2(KMAX+1) | Fault size in vector frames |
| strobe | input | 1 | End-of-vector pulse; pushes good_in into the history |
| good_in | input | 2 | Fault-free net value, three-valued code |
| fault_out | output | 2 | Faulty net value, three-valued code |

## Verification
The bench goes after the unknown values left by reset. A cell that started from 0 or 1 would let a rising value through as 1, or pin it to 0, instead of reporting unknown. It checks that only the newest `size` frames count, by hiding a 0 just beyond the window. An off-by-one selection would then hold back a transition that has already cleared. It drives the net between strobes and checks that the history does not take those values. It also checks that history recorded while the cell is disabled still counts. A design that shifted on every cycle, or stopped shifting while disabled, would give the wrong held values. Random runs mix unknown inputs with both unknown codes and sizes beyond KMAX. These catch a result driven as 2'b11 and a missing bypass for sizes out of range.

// File: rtl/tfi_cell.sv
module tfi_cell #(
  parameter int KMAX = 8,
  localparam int SZW = $clog2(KMAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           rise_mode,
  input  logic [SZW-1:0] size,
  input  logic           strobe,
  input  logic [1:0]     good_in,
  output logic [1:0]     fault_out
);

  localparam logic [1:0] V0 = 2'b00;
  localparam logic [1:0] V1 = 2'b01;
  localparam logic [1:0] VX = 2'b10;

  logic [1:0] hist [KMAX];
  logic       active;
  logic       has0, has1, only0, only1;
  logic [1:0] inj;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < KMAX; i++) hist[i] <= VX;
    end else if (strobe) begin
      hist[0] <= good_in;
      for (int i = 1; i < KMAX; i++) hist[i] <= hist[i-1];
    end
  end

  assign active = en && (size != '0) && (size <= SZW'(KMAX));

  always_comb begin
    has0  = (good_in == V0);
    has1  = (good_in == V1);
    only0 = has0;
    only1 = has1;
    for (int i = 0; i < KMAX; i++) begin
      if (SZW'(i) < size) begin
        has0  = has0  | (hist[i] == V0);
        has1  = has1  | (hist[i] == V1);
        only0 = only0 & (hist[i] == V0);
        only1 = only1 & (hist[i] == V1);
      end
    end
    if (rise_mode) inj = has0 ? V0 : (only1 ? V1 : VX);
    else           inj = has1 ? V1 : (only0 ? V0 : VX);
  end

  assign fault_out = active ? inj : good_in;

endmodule

// File: rtl/tfi_cell_chk.sv
module tfi_cell_chk #(
  parameter int KMAX = 8,
  parameter int SZW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           rise_mode,
  input logic [SZW-1:0] size,
  input logic           strobe,
  input logic [1:0]     good_in,
  input logic [1:0]     fault_out
);

  logic act;
  assign act = en && (size != '0) && (size <= SZW'(KMAX));

  p_x_code_r1: assert property (@(posedge clk) disable iff (rst)
    act |-> fault_out != 2'b11);

  p_rise_low_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (act && rise_mode && good_in == 2'b00) |-> fault_out == 2'b00);

  p_rise_no_early_one_r2: assert property (@(posedge clk) disable iff (rst)
    (act && rise_mode && fault_out == 2'b01) |-> good_in == 2'b01);

  p_fall_high_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (act && !rise_mode && good_in == 2'b01) |-> fault_out == 2'b01);

  p_size1_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (act && rise_mode && size == SZW'(1) && $past(strobe) && !$past(rst)
     && $past(good_in) == 2'b00 && good_in == 2'b01) |-> fault_out == 2'b00);

  p_post_reset_x_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && act && rise_mode && good_in == 2'b01) |-> fault_out == 2'b10);

  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    (!en || size == '0 || size > SZW'(KMAX)) |-> fault_out == good_in);

endmodule

bind tfi_cell tfi_cell_chk #(.KMAX(KMAX), .SZW(SZW)) u_chk (.*);

// File: tb/tfi_cell_bench.sv
module tfi_cell_bench;
  localparam int KMAX = 8;
  localparam int SZW  = $clog2(KMAX + 1);

  logic           clk = 1'b0;
  logic           rst, en, rise_mode, strobe;
  logic [SZW-1:0] size;
  logic [1:0]     good_in, fault_out;

  int  mh [KMAX];
  int  checks = 0, fails = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  tfi_cell #(.KMAX(KMAX)) u_tfi_cell (.clk, .rst, .en, .rise_mode, .size,
                                      .strobe, .good_in, .fault_out);

  function automatic int tri3(input logic [1:0] v);
    return (v == 2'b00) ? 0 : (v == 2'b01) ? 1 : 2;
  endfunction

  function automatic logic [1:0] model(input bit e, input bit m, input int s,
                                       input logic [1:0] g);
    int n0, n1, tot;
    if (!e || s == 0 || s > KMAX) return g;
    tot = s + 1;
    n0 = (tri3(g) == 0); n1 = (tri3(g) == 1);
    for (int i = 0; i < s; i++) begin
      n0 += (mh[i] == 0); n1 += (mh[i] == 1);
    end
    if (m) return (n0 > 0) ? 2'b00 : (n1 == tot) ? 2'b01 : 2'b10;
    return (n1 > 0) ? 2'b01 : (n0 == tot) ? 2'b00 : 2'b10;
  endfunction

  task automatic step(input bit r, input bit e, input bit m, input int s,
                      input bit st, input logic [1:0] g, input string tag,
                      input bit chk);
    logic [1:0] exp;
    string t;
    @(negedge clk);
    rst = r; en = e; rise_mode = m; size = SZW'(s); strobe = st; good_in = g;
    #1;
    if (chk) begin
      exp = model(e, m, s, g);
      t = tag;
      if (t == "") t = (!e) ? "R6" : (s == 0 || s > KMAX) ? "R7" : m ? "R2" : "R3";
      checks++;
      if (fault_out !== exp) begin
        fails++;
        $display("FAIL %s: fault_out=%b expected %b", t, fault_out, exp);
      end
      if (e && s > 0 && s <= KMAX) begin
        checks++;
        if (fault_out === 2'b11) begin
          fails++;
          $display("FAIL R1: fault_out=%b expected 10", fault_out);
        end
      end
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < KMAX; i++) mh[i] = 2;
    end else if (st) begin
      for (int i = KMAX - 1; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = tri3(g);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit e, m, st, r;
    int s;
    logic [1:0] g;
    seed = $urandom(32'h5eed_7a1c);
    for (int i = 0; i < KMAX; i++) mh[i] = 2;
    rst = 1; en = 0; rise_mode = 1; size = '0; strobe = 0; good_in = 2'b00;
    step(1, 1, 1, 1, 0, 2'b00, "", 0);
    step(1, 1, 1, 1, 0, 2'b00, "", 0);
    // R5: reset leaves unknown history
    step(0, 1, 1, 1, 0, 2'b01, "R5", 1);
    step(0, 1, 1, 1, 0, 2'b00, "R5", 1);
    step(0, 1, 0, KMAX, 0, 2'b00, "R5", 1);
    // R2: rise held for size frames, then released
    for (int i = 0; i < KMAX; i++) step(0, 1, 1, 3, 1, 2'b00, "R2", 1);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 3, 1, 2'b01, "R2", 1);
    // R8: stale 0 just beyond the window is ignored
    for (int i = 0; i < 3; i++) step(0, 1, 1, 3, 1, 2'b01, "R8", 1);
    step(0, 1, 1, 2, 1, 2'b00, "R8", 1);
    step(0, 1, 1, 2, 1, 2'b01, "R8", 1);
    step(0, 1, 1, 1, 1, 2'b01, "R8", 1);
    step(0, 1, 1, 1, 0, 2'b01, "R8", 1);
    // R4: values between strobes never enter the history
    for (int i = 0; i < KMAX; i++) step(0, 1, 1, KMAX, 1, 2'b01, "R4", 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, KMAX, 0, 2'b00, "R4", 1);
    step(0, 1, 1, KMAX, 0, 2'b01, "R4", 1);
    // R3: fall held, with an unknown frame inside the window
    step(0, 1, 0, 2, 1, 2'b00, "R3", 1);
    step(0, 1, 0, 2, 1, 2'b10, "R3", 1);
    step(0, 1, 0, 2, 1, 2'b00, "R3", 1);
    step(0, 1, 0, 2, 1, 2'b00, "R3", 1);
    step(0, 1, 0, 2, 0, 2'b00, "R3", 1);
    // R6: history keeps shifting while disabled
    for (int i = 0; i < KMAX; i++) step(0, 0, 1, KMAX, 1, 2'b01, "R6", 1);
    step(0, 1, 1, KMAX, 0, 2'b01, "R6", 1);
    // R7: out-of-range sizes bypass
    step(0, 1, 1, 0, 0, 2'b11, "R7", 1);
    step(0, 1, 0, KMAX + 1, 0, 2'b10, "R7", 1);
    // R1: unknown inputs in both codes come out as 10
    step(0, 1, 1, 1, 1, 2'b11, "R1", 1);
    step(0, 1, 0, 1, 0, 2'b11, "R1", 1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      r  = ($urandom % 100) < 2;
      e  = ($urandom % 10) != 0;
      m  = $urandom % 2;
      st = ($urandom % 10) < 7;
      s  = $urandom % (1 << SZW);
      g  = (($urandom % 8) == 0) ? 2'($urandom % 4) : {1'b0, 1'($urandom % 2)};
      step(r, e, m, s, st, g, "", !r);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule